// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative page translation cache. Every slot pairs a virtual page number with a physical page number and carries an address-space number, a global flag, one read-enable and one write-enable bit per privilege mode, and two fault-on-access flags (read and write). The lookup port compares a presented page number and address-space number against all slots in parallel. It returns the hit flag, the index of the winning slot and that slot's fields in the same cycle. A registered copy of the hit flag and index follows one cycle later.

Refills go through an insert port. An insert always overwrites the slot named by a rotating replacement pointer, whatever that slot holds, and then steps the pointer. The pointer is visible at the ports and can be stepped on its own, so maintenance software can aim at a particular slot. Three invalidate commands keep the contents coherent with the page tables. The first wipes every slot. The second drops every non-global slot, which is what a process switch needs. The third drops the slots that translate one given address for one given address space. Permission checks, table walks and fault reporting belong to the surrounding pipeline.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only if some slot is valid, its tag equals `lk_vpn`, and either its global flag is 1 or its stored address-space number equals `lk_asn`; otherwise `lk_hit` is 0.
- R2: With `ins_en` high, at the clock edge the slot at `ptr_idx` is overwritten and becomes valid. Its tag is `ins_va[VA_W-1:PAGE_SHIFT]`, and its other fields are taken from the `ins_*` inputs. This holds even if the slot already held a valid entry.
- R3: `flush_all` makes every slot invalid and sets `ptr_idx` to 0 at the clock edge.
- R4: `flush_proc` invalidates every slot whose global flag is 0 and keeps every global slot; it does not move `ptr_idx`.
- R5: `flush_addr` invalidates every valid slot whose tag equals `flush_va[VA_W-1:PAGE_SHIFT]` and that is either global or holds address-space number `flush_asn`. All other slots stay unchanged.
- R6: Each slot stores the read-enable and write-enable masks exactly as inserted, with bit m standing for privilege mode m. On a hit the masks and both fault flags of the winning slot appear on the `hit_*` outputs.
- R7: `ptr_idx` increases by one at each edge where `ins_en` or `ptr_adv` is high; it advances once even when both are high, and wraps from ENTRIES-1 to 0. `ptr_adv` alone writes no slot.
- R8: When several slots hit, the one with the lowest index wins: its index and fields are returned.
- R9: `lk_hit_q` and `lk_idx_q` equal the previous cycle's `lk_hit` and `lk_idx`. A lookup made in the same cycle as an insert or flush sees the contents from before that edge.
- R10: `flush_all` overrides any insert, pointer step or selective flush in the same cycle. An insert in the same cycle as `flush_proc` or `flush_addr` leaves the newly written slot valid. `flush_proc` and `flush_addr` together apply both conditions.
- R11: After reset every slot is invalid, `ptr_idx` is 0 and `lk_hit_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Page number to look up |
| lk_asn | input | ASN_W | Address-space number of the lookup |
| lk_hit | output | 1 | Combinational hit |
| lk_idx | output | IDX_W | Index of the winning slot |
| hit_ppn | output | PPN_W | Physical page number of the winning slot (0 on miss) |
| hit_asn | output | ASN_W | Stored address-space number of the winning slot |
| hit_glb | output | 1 | Global flag of the winning slot |
| hit_rd_en | output | MODES | Read-enable mask, bit m = mode m |
| hit_wr_en | output | MODES | Write-enable mask, bit m = mode m |
| hit_fault_rd | output | 1 | Fault-on-read flag |
| hit_fault_wr | output | 1 | Fault-on-write flag |
| lk_hit_q | output | 1 | Hit, registered one cycle later |
| lk_idx_q | output | IDX_W | Index, registered one cycle later |
| ins_en | input | 1 | Write the slot at the pointer |
| ins_va | input | VA_W | Virtual address of the new mapping |
| ins_ppn | input | PPN_W | Physical page number |
| ins_asn | input | ASN_W | Address-space number |
| ins_glb | input | 1 | Global flag |
| ins_rd_en | input | MODES | Read-enable mask |
| ins_wr_en | input | MODES | Write-enable mask |
| ins_fault_rd | input | 1 | Fault-on-read flag |
| ins_fault_wr | input | 1 | Fault-on-write flag |
| ptr_adv | input | 1 | Step the pointer without writing |
| ptr_idx | output | IDX_W | Current replacement pointer |
| flush_all | input | 1 | Invalidate every slot, reset pointer |
| flush_proc | input | 1 | Invalidate non-global slots |
| flush_addr | input | 1 | Invalidate slots mapping one address |
| flush_va | input | VA_W | Address for `flush_addr` |
| flush_asn | input | ASN_W | Address-space number for `flush_addr` |

## Verification
Several properties are checked on every cycle. They cover the pointer range, its wrap and its reset to zero, and the fact that a selective flush leaves the pointer where it was. They also cover the per-slot effect of each command: a written slot becomes valid, global slots survive a process flush, and slots whose tag differs survive an address flush. Finally they check that the returned index is a matching slot with no lower-numbered match, and that the registered hit tracks the combinational one. What only the bench scenarios can show is the end-to-end content behaviour: the fields returned on later lookups, overwriting by the rotating pointer, address-space selection with duplicate tags, and the mix of commands in one cycle. A behavioural model compares all outputs every clock under directed and random traffic.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
  // Invalidate request decoded once at the top and broadcast to every slot.
  typedef enum logic [1:0] {
    KILL_NONE   = 2'd0,
    KILL_ALL    = 2'd1,
    KILL_SELECT = 2'd2
  } kill_e;
endpackage

// File: rtl/asn_tlb_slot.sv
module asn_tlb_slot
  import asn_tlb_pkg::*;
#(
  parameter int VPN_W = 19,
  parameter int PPN_W = 20,
  parameter int ASN_W = 8,
  parameter int MODES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  kill_e            kill,
  input  logic             proc_sel,
  input  logic             addr_sel,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [ASN_W-1:0] fl_asn,
  input  logic             wr,
  input  logic [VPN_W-1:0] w_vpn,
  input  logic [PPN_W-1:0] w_ppn,
  input  logic [ASN_W-1:0] w_asn,
  input  logic             w_glb,
  input  logic [MODES-1:0] w_rd,
  input  logic [MODES-1:0] w_wr,
  input  logic             w_frd,
  input  logic             w_fwr,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             valid,
  output logic             match,
  output logic [PPN_W-1:0] s_ppn,
  output logic [ASN_W-1:0] s_asn,
  output logic             s_glb,
  output logic [MODES-1:0] s_rd,
  output logic [MODES-1:0] s_wr,
  output logic             s_frd,
  output logic             s_fwr
);
  logic [VPN_W-1:0] tag_q;
  logic             drop_proc;
  logic             drop_addr;

  assign drop_proc = proc_sel && !s_glb;
  assign drop_addr = addr_sel && (tag_q == fl_vpn) && (s_glb || (s_asn == fl_asn));
  assign match     = valid && (tag_q == lk_vpn) && (s_glb || (s_asn == lk_asn));

  // Valid bit: full wipe beats a write, a write beats a selective drop.
  always_ff @(posedge clk) begin
    if (rst)                                             valid <= 1'b0;
    else if (kill == KILL_ALL)                           valid <= 1'b0;
    else if (wr)                                         valid <= 1'b1;
    else if (kill == KILL_SELECT && (drop_proc || drop_addr)) valid <= 1'b0;
  end

  // Payload carries no reset; it is qualified by the valid bit.
  always_ff @(posedge clk) begin
    if (wr) begin
      tag_q <= w_vpn;
      s_ppn <= w_ppn;
      s_asn <= w_asn;
      s_glb <= w_glb;
      s_rd  <= w_rd;
      s_wr  <= w_wr;
      s_frd <= w_frd;
      s_fwr <= w_fwr;
    end
  end

  AST_SLOT_FILL: assert property (@(posedge clk) disable iff (rst)
    (wr && kill != KILL_ALL) |=> (valid && tag_q == $past(w_vpn))); // R2
  AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (kill == KILL_ALL) |=> !valid); // R3
  AST_SLOT_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (kill == KILL_SELECT && proc_sel && !addr_sel && valid && s_glb) |=> valid); // R4
  AST_SLOT_DROP_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (kill == KILL_SELECT && proc_sel && !wr && valid && !s_glb) |=> !valid); // R4
  AST_SLOT_OTHER_TAG: assert property (@(posedge clk) disable iff (rst)
    (kill == KILL_SELECT && addr_sel && !proc_sel && valid && tag_q != fl_vpn) |=> valid); // R5
endmodule

// File: rtl/asn_tlb_rptr.sv
module asn_tlb_rptr #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear)  ptr <= '0;
    else if (step)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(ptr) < ENTRIES); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && ptr == LAST) |=> (ptr == '0)); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ptr == '0)); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(ptr)); // R4
endmodule

// File: rtl/asn_tlb_pick.sv
module asn_tlb_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0] match,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 20,
  parameter int ASN_W      = 8,
  parameter int MODES      = 4,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [ASN_W-1:0] hit_asn,
  output logic             hit_glb,
  output logic [MODES-1:0] hit_rd_en,
  output logic [MODES-1:0] hit_wr_en,
  output logic             hit_fault_rd,
  output logic             hit_fault_wr,
  output logic             lk_hit_q,
  output logic [IDX_W-1:0] lk_idx_q,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_glb,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_fault_rd,
  input  logic             ins_fault_wr,
  input  logic             ptr_adv,
  output logic [IDX_W-1:0] ptr_idx,
  input  logic             flush_all,
  input  logic             flush_proc,
  input  logic             flush_addr,
  input  logic [VA_W-1:0]  flush_va,
  input  logic [ASN_W-1:0] flush_asn
);
  kill_e              kill;
  logic [VPN_W-1:0]   ins_vpn;
  logic [VPN_W-1:0]   fl_vpn;
  logic [ENTRIES-1:0] slot_valid;
  logic [ENTRIES-1:0] slot_match;
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [ASN_W-1:0]   e_asn [ENTRIES];
  logic               e_glb [ENTRIES];
  logic [MODES-1:0]   e_rd  [ENTRIES];
  logic [MODES-1:0]   e_wr  [ENTRIES];
  logic               e_frd [ENTRIES];
  logic               e_fwr [ENTRIES];
  logic [ENTRIES-1:0] below_mask;

  assign ins_vpn = ins_va[VA_W-1:PAGE_SHIFT];
  assign fl_vpn  = flush_va[VA_W-1:PAGE_SHIFT];

  always_comb begin
    if (flush_all)                    kill = KILL_ALL;
    else if (flush_proc || flush_addr) kill = KILL_SELECT;
    else                              kill = KILL_NONE;
  end

  asn_tlb_rptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rptr (
    .clk   (clk),
    .rst   (rst),
    .clear (flush_all),
    .step  (ins_en || ptr_adv),
    .ptr   (ptr_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    asn_tlb_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .kill     (kill),
      .proc_sel (flush_proc),
      .addr_sel (flush_addr),
      .fl_vpn   (fl_vpn),
      .fl_asn   (flush_asn),
      .wr       (ins_en && (ptr_idx == IDX_W'(g))),
      .w_vpn    (ins_vpn),
      .w_ppn    (ins_ppn),
      .w_asn    (ins_asn),
      .w_glb    (ins_glb),
      .w_rd     (ins_rd_en),
      .w_wr     (ins_wr_en),
      .w_frd    (ins_fault_rd),
      .w_fwr    (ins_fault_wr),
      .lk_vpn   (lk_vpn),
      .lk_asn   (lk_asn),
      .valid    (slot_valid[g]),
      .match    (slot_match[g]),
      .s_ppn    (e_ppn[g]),
      .s_asn    (e_asn[g]),
      .s_glb    (e_glb[g]),
      .s_rd     (e_rd[g]),
      .s_wr     (e_wr[g]),
      .s_frd    (e_frd[g]),
      .s_fwr    (e_fwr[g])
    );
  end

  asn_tlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .match (slot_match),
    .hit   (lk_hit),
    .idx   (lk_idx)
  );

  // Field mux of the winning slot; zeros on a miss.
  always_comb begin
    hit_ppn      = '0;
    hit_asn      = '0;
    hit_glb      = 1'b0;
    hit_rd_en    = '0;
    hit_wr_en    = '0;
    hit_fault_rd = 1'b0;
    hit_fault_wr = 1'b0;
    if (lk_hit) begin
      hit_ppn      = e_ppn[lk_idx];
      hit_asn      = e_asn[lk_idx];
      hit_glb      = e_glb[lk_idx];
      hit_rd_en    = e_rd[lk_idx];
      hit_wr_en    = e_wr[lk_idx];
      hit_fault_rd = e_frd[lk_idx];
      hit_fault_wr = e_fwr[lk_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit_q <= 1'b0;
      lk_idx_q <= '0;
    end else begin
      lk_hit_q <= lk_hit;
      lk_idx_q <= lk_idx;
    end
  end

  assign below_mask = (ENTRIES'(1) << lk_idx) - ENTRIES'(1);

  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> slot_match[lk_idx]); // R1
  AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (slot_match == '0)); // R1
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> ((slot_match & below_mask) == '0)); // R8
  AST_HIT_Q_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lk_hit_q == $past(lk_hit) && lk_idx_q == $past(lk_idx))); // R9
  AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> ($countones(slot_valid) == 0)); // R3
endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
  localparam int CLK_P = 10;
  localparam int N     = 16;

  logic        clk = 0;
  logic        rst;
  logic [18:0] lk_vpn;
  logic [7:0]  lk_asn;
  logic        lk_hit;
  logic [3:0]  lk_idx;
  logic [19:0] hit_ppn;
  logic [7:0]  hit_asn;
  logic        hit_glb;
  logic [3:0]  hit_rd_en, hit_wr_en;
  logic        hit_fault_rd, hit_fault_wr;
  logic        lk_hit_q;
  logic [3:0]  lk_idx_q;
  logic        ins_en;
  logic [31:0] ins_va;
  logic [19:0] ins_ppn;
  logic [7:0]  ins_asn;
  logic        ins_glb;
  logic [3:0]  ins_rd_en, ins_wr_en;
  logic        ins_fault_rd, ins_fault_wr;
  logic        ptr_adv;
  logic [3:0]  ptr_idx;
  logic        flush_all, flush_proc, flush_addr;
  logic [31:0] flush_va;
  logic [7:0]  flush_asn;

  asn_tlb u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference state
  bit m_v [N];
  int m_tag [N], m_ppn [N], m_asn [N], m_rd [N], m_wr [N];
  bit m_g [N], m_fr [N], m_fw [N];
  int m_ptr;
  bit exp_hq;
  int exp_iq;
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(string req);
    bit mh = 0;
    int mi = 0;
    #2;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_tag[i] == int'(lk_vpn) && (m_g[i] || m_asn[i] == int'(lk_asn))) begin
        mh = 1; mi = i;
      end
    chk(req, "hit", lk_hit, mh);
    if (mh) begin
      chk(req, "idx", lk_idx, mi);
      chk(req, "ppn", hit_ppn, m_ppn[mi]);
      chk(req, "asn", hit_asn, m_asn[mi]);
      chk(req, "glb", hit_glb, m_g[mi]);
      chk(req, "rd_en", hit_rd_en, m_rd[mi]);
      chk(req, "wr_en", hit_wr_en, m_wr[mi]);
      chk(req, "fault_rd", hit_fault_rd, m_fr[mi]);
      chk(req, "fault_wr", hit_fault_wr, m_fw[mi]);
    end
    chk(req, "hit_q", lk_hit_q, exp_hq);
    if (exp_hq) chk(req, "idx_q", lk_idx_q, exp_iq);
    chk(req, "ptr", ptr_idx, m_ptr);
    @(posedge clk);
    if (rst) begin
      exp_hq = 0; exp_iq = 0; m_ptr = 0;
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      exp_hq = mh; exp_iq = mi;
      if (flush_all) begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_ptr = 0;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (flush_proc && !m_g[i]) m_v[i] = 0;
          if (flush_addr && m_tag[i] == int'(flush_va[31:13]) &&
              (m_g[i] || m_asn[i] == int'(flush_asn))) m_v[i] = 0;
        end
        if (ins_en) begin
          m_v[m_ptr] = 1;     m_tag[m_ptr] = int'(ins_va[31:13]);
          m_ppn[m_ptr] = int'(ins_ppn); m_asn[m_ptr] = int'(ins_asn);
          m_g[m_ptr] = ins_glb; m_rd[m_ptr] = int'(ins_rd_en);
          m_wr[m_ptr] = int'(ins_wr_en); m_fr[m_ptr] = ins_fault_rd;
          m_fw[m_ptr] = ins_fault_wr;
        end
        if (ins_en || ptr_adv) m_ptr = (m_ptr + 1) % N;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ins_en = 0; ptr_adv = 0; flush_all = 0; flush_proc = 0; flush_addr = 0;
  endtask

  task automatic put(string req, int vpn, int ppn, int asn, bit g, int rd, int wr, bit fr, bit fw);
    ins_en = 1; ins_va = {vpn[18:0], 13'(vpn * 7 + 3)};
    ins_ppn = 20'(ppn); ins_asn = 8'(asn); ins_glb = g;
    ins_rd_en = 4'(rd); ins_wr_en = 4'(wr); ins_fault_rd = fr; ins_fault_wr = fw;
    tick(req);
    ins_en = 0;
  endtask

  task automatic look(string req, int vpn, int asn);
    lk_vpn = 19'(vpn); lk_asn = 8'(asn);
    tick(req);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; idle_inputs();
    lk_vpn = 0; lk_asn = 0; ins_va = 0; ins_ppn = 0; ins_asn = 0; ins_glb = 0;
    ins_rd_en = 0; ins_wr_en = 0; ins_fault_rd = 0; ins_fault_wr = 0;
    flush_va = 0; flush_asn = 0;
    m_ptr = 0; exp_hq = 0; exp_iq = 0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) tick("R11");
    rst = 0;
    // R11: empty after reset
    look("R11", 0, 0);
    chk("R11", "ptr after reset", ptr_idx, 0);

    // R2 R6: fill every slot, varied masks and flags
    for (int k = 0; k < N; k++)
      put("R2", 'h100 + k, 'h5000 + k * 3, k % 4, (k % 5) == 0, k, 15 - k, k[0], k[1]);
    for (int k = 0; k < N; k++) begin
      look("R6", 'h100 + k, k % 4);
      look("R1", 'h100 + k, (k % 4) + 1);   // wrong space: hits only globals
    end
    look("R1", 'h7ff, 0);

    // R7: overwrite by wrap, then duplicates for R8
    put("R7", 'h200, 'h11, 3, 0, 1, 2, 0, 0);
    chk("R7", "ptr after wrap write", ptr_idx, 1);
    look("R2", 'h100, 0);
    put("R8", 'h300, 'h21, 5, 0, 3, 3, 0, 0);
    put("R8", 'h300, 'h22, 6, 0, 3, 3, 0, 0);
    put("R8", 'h300, 'h23, 9, 1, 3, 3, 1, 1);
    look("R8", 'h300, 6);
    look("R8", 'h300, 5);
    look("R8", 'h300, 77);

    // R4: process flush with a lookup in the same cycle (R9)
    lk_vpn = 'h300; lk_asn = 5; flush_proc = 1; tick("R9"); flush_proc = 0;
    look("R4", 'h300, 5);
    look("R4", 'h100, 0);
    look("R4", 'h105, 0);
    chk("R4", "ptr unchanged", ptr_idx, 4);

    // R5: address flush
    put("R5", 'h400, 'h31, 2, 0, 1, 1, 0, 0);
    put("R5", 'h400, 'h32, 3, 0, 1, 1, 0, 0);
    flush_addr = 1; flush_va = {19'h400, 13'h55}; flush_asn = 2; look("R5", 'h400, 2);
    flush_addr = 0;
    look("R5", 'h400, 2);
    look("R5", 'h400, 3);
    flush_addr = 1; flush_va = {19'h300, 13'h0}; flush_asn = 0; look("R5", 'h300, 0);
    flush_addr = 0;
    look("R5", 'h300, 9);

    // R7: pointer steps alone, wraps, and steps once with insert
    for (int k = 0; k < N + 2; k++) begin ptr_adv = 1; look("R7", 'h400, 3); end
    ptr_adv = 1; put("R7", 'h500, 'h41, 1, 0, 2, 2, 0, 0); ptr_adv = 0;
    look("R7", 'h500, 1);

    // R10: precedence
    flush_proc = 1; put("R10", 'h600, 'h51, 4, 0, 1, 1, 0, 0); flush_proc = 0;
    look("R10", 'h600, 4);
    flush_all = 1; ptr_adv = 1; put("R10", 'h700, 'h61, 4, 1, 1, 1, 0, 0);
    flush_all = 0; ptr_adv = 0;
    look("R3", 'h700, 4);
    look("R3", 'h600, 4);
    chk("R3", "ptr after full flush", ptr_idx, 0);

    // Random traffic over a small page range
    for (int k = 0; k < 3000; k++) begin
      idle_inputs();
      lk_vpn = 19'($urandom_range(0, 7)); lk_asn = 8'($urandom_range(0, 3));
      case ($urandom_range(0, 19))
        0:       flush_all = 1;
        1, 2:    flush_proc = 1;
        3, 4, 5: flush_addr = 1;
        6:       ptr_adv = 1;
        default: if ($urandom_range(0, 1) == 1) ins_en = 1;
      endcase
      if ($urandom_range(0, 9) == 0) ins_en = 1;
      if ($urandom_range(0, 9) == 0) flush_proc = 1;
      ins_va = {19'($urandom_range(0, 7)), 13'($urandom)};
      ins_ppn = 20'($urandom); ins_asn = 8'($urandom_range(0, 3));
      ins_glb = ($urandom_range(0, 3) == 0); ins_rd_en = 4'($urandom);
      ins_wr_en = 4'($urandom); ins_fault_rd = 1'($urandom); ins_fault_wr = 1'($urandom);
      flush_va = {19'($urandom_range(0, 7)), 13'($urandom)};
      flush_asn = 8'($urandom_range(0, 3));
      tick("R1 R2 R4 R5 R7 R8 R9 R10");
    end
    idle_inputs();
    look("R9", 1, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule